// File: doc/BRIEF.md
# Split-Transaction Data Phase Driver

This block drives the data half of a transaction on a 64-bit shared system bus for one agent. A local client hands over a request that is either a whole 32-byte cache line or a single partial beat with byte enables. The block stores the request and waits until the transaction sits at the head of the in-order queue. It also waits until the bus is free, and for writes until the target has signalled that it is ready. It then drives the data-ready and data-busy strobes and places the beats on the data lines.

A line moves as four consecutive beats in ascending 8-byte chunk order, with data-busy held across them. After data-busy goes inactive, one release clock follows during which the bus still counts as held. A partial transfer takes one clock, pulses data-ready only and never touches data-busy. All bus strobes are active-low at the ports and active-high inside.

Top module: `dphase_drv`

## Requirements
- R1: After reset, `drdy_n` and `dbsy_n` are 1, `bus_held` is 0, `d_out` is zero and `req_ready` is 1. A request is taken on a clock where `req_valid` and `req_ready` are both 1. `req_ready` stays 0 from then until the phase is complete.
- R2: For a read (`req_write`=0), the first beat appears on the clock after an edge at which the driver is waiting, `ioq_head` is 1 and `bus_busy_n` is 1. While either condition is missing, `drdy_n` stays 1.
- R3: For a write (`req_write`=1), the same edge must also see `trdy_n` at 0. If `trdy_n` is 1, or `bus_busy_n` is 0, no beat starts.
- R4: A line (`req_line`=1) drives `drdy_n` low for exactly four consecutive clocks. Beat i (i = 0..3) carries `req_data[64*i+63:64*i]`.
- R5: During a line, `dbsy_n` is 0 on each of the four beat clocks and 1 on every other clock.
- R6: A partial transfer (`req_line`=0) drives `drdy_n` low for one clock and keeps `dbsy_n` at 1. On that beat, `d_out[8*j+7:8*j]` equals `req_data[8*j+7:8*j]` when `req_be[j]` is 1 and zero when it is 0.
- R7: `bus_held` is 1 on every beat clock. After a line it stays 1 for exactly one more clock, with both strobes inactive. After a partial beat it drops at once. `req_ready` returns to 1 on the clock where `bus_held` falls.
- R8: `d_out` is zero on every clock where `drdy_n` is 1.
- R9: Request inputs presented while `req_ready` is 0 are ignored. The beats of the current phase carry the values captured when the request was taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Driver idle, request can be taken |
| req_write | input | 1 | 1 = write data, 0 = read return data |
| req_line | input | 1 | 1 = full line of four beats, 0 = single partial beat |
| req_be | input | 8 | Byte-lane enables for a partial beat, bit j covers byte j |
| req_data | input | 256 | Line payload; the low 64 bits serve a partial beat |
| ioq_head | input | 1 | Transaction is at the head of the in-order queue |
| trdy_n | input | 1 | Target ready, active low |
| bus_busy_n | input | 1 | Sampled data-bus busy, active low |
| drdy_n | output | 1 | Data ready strobe, active low |
| dbsy_n | output | 1 | Data busy strobe, active low |
| d_out | output | 64 | Data lines |
| bus_held | output | 1 | Data bus is held by this agent |

## Verification
A stuck or skipped sequencer state shows at the ports within one clock. A missing release state makes `req_ready` rise one clock early after a line. A beat counter that wraps wrongly shows up as a fifth data-ready clock, or as a chunk out of order on the next beat. A start gate that ignores the queue head, the bus-busy input or target-ready produces a data-ready edge during a stall cycle, on the clock after the bad sample. Capture logic that follows live inputs corrupts the very next beat, because the bench changes the request inputs during every phase.

// File: rtl/dphase_pkg.sv
package dphase_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_WAIT = 2'd1,
    PH_XFER = 2'd2,
    PH_REL  = 2'd3
  } ph_state_t;

endpackage

// File: rtl/dphase_gate.sv
module dphase_gate (
  input  logic is_write,
  input  logic ioq_head,
  input  logic trdy,
  input  logic bus_busy,
  output logic go
);

  // A phase may open only at the queue head on a free bus; writes also need target ready.
  function automatic logic may_open(input logic wr, input logic head,
                                    input logic tgt, input logic busy);
    return head && !busy && (!wr || tgt);
  endfunction

  always_comb go = may_open(is_write, ioq_head, trdy, bus_busy);

endmodule

// File: rtl/dphase_seq.sv
module dphase_seq
  import dphase_pkg::*;
#(
  parameter int BEATS = 4,
  localparam int CNT_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_fire,
  input  logic             go,
  input  logic             is_line,
  output logic [CNT_W-1:0] beat,
  output logic             drdy,
  output logic             dbsy,
  output logic             held,
  output logic             ready
);

  ph_state_t        state_q, state_d;
  logic [CNT_W-1:0] beat_q, beat_d;
  logic             ev_start, ev_last;

  function automatic logic is_final(input logic line, input logic [CNT_W-1:0] idx);
    return !line || (idx == CNT_W'(BEATS - 1));
  endfunction

  always_comb begin
    ready    = (state_q == PH_IDLE);
    drdy     = (state_q == PH_XFER);
    dbsy     = drdy && is_line;
    held     = drdy || (state_q == PH_REL);
    ev_start = (state_q == PH_WAIT) && go;
    ev_last  = drdy && is_final(is_line, beat_q);
    beat     = beat_q;
  end

  always_comb begin
    state_d = state_q;
    beat_d  = beat_q;
    unique case (state_q)
      PH_IDLE: if (req_fire) state_d = PH_WAIT;
      PH_WAIT: if (ev_start) begin
        state_d = PH_XFER;
        beat_d  = '0;
      end
      PH_XFER: begin
        if (ev_last) state_d = is_line ? PH_REL : PH_IDLE;
        else         beat_d  = beat_q + CNT_W'(1);
      end
      PH_REL:  state_d = PH_IDLE;
      default: state_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
      beat_q  <= '0;
    end else begin
      state_q <= state_d;
      beat_q  <= beat_d;
    end
  end

endmodule

// File: rtl/dphase_lane.sv
module dphase_lane #(
  parameter int DATA_W = 64,
  parameter int BEATS  = 4,
  localparam int LANES = DATA_W / 8,
  localparam int LINE_W = DATA_W * BEATS,
  localparam int CNT_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic [LINE_W-1:0] line_data,
  input  logic [LANES-1:0]  be,
  input  logic              is_line,
  input  logic [CNT_W-1:0]  beat,
  input  logic              drdy,
  output logic [DATA_W-1:0] d_out
);

  logic [DATA_W-1:0] part_word;

  function automatic logic [DATA_W-1:0] chunk(input logic [LINE_W-1:0] d,
                                              input logic [CNT_W-1:0] idx);
    return d[int'(idx)*DATA_W +: DATA_W];
  endfunction

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    assign part_word[j*8 +: 8] = be[j] ? line_data[j*8 +: 8] : 8'h00;
  end

  always_comb begin
    if (!drdy)        d_out = '0;
    else if (is_line) d_out = chunk(line_data, beat);
    else              d_out = part_word;
  end

endmodule

// File: rtl/dphase_drv.sv
module dphase_drv #(
  parameter int DATA_W = 64,
  parameter int BEATS  = 4,
  localparam int LANES = DATA_W / 8,
  localparam int LINE_W = DATA_W * BEATS,
  localparam int CNT_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_line,
  input  logic [LANES-1:0]  req_be,
  input  logic [LINE_W-1:0] req_data,
  input  logic              ioq_head,
  input  logic              trdy_n,
  input  logic              bus_busy_n,
  output logic              drdy_n,
  output logic              dbsy_n,
  output logic [DATA_W-1:0] d_out,
  output logic              bus_held
);

  logic              cur_write, cur_line;
  logic [LANES-1:0]  cur_be;
  logic [LINE_W-1:0] cur_data;
  logic              req_fire, go;
  logic              drdy_a, dbsy_a, held_a;
  logic [CNT_W-1:0]  beat;

  assign req_fire = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_write <= 1'b0;
      cur_line  <= 1'b0;
      cur_be    <= '0;
      cur_data  <= '0;
    end else if (req_fire) begin
      cur_write <= req_write;
      cur_line  <= req_line;
      cur_be    <= req_be;
      cur_data  <= req_data;
    end
  end

  dphase_gate u_gate (
    .is_write (cur_write),
    .ioq_head (ioq_head),
    .trdy     (!trdy_n),
    .bus_busy (!bus_busy_n),
    .go       (go)
  );

  dphase_seq #(.BEATS(BEATS)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_fire (req_fire),
    .go       (go),
    .is_line  (cur_line),
    .beat     (beat),
    .drdy     (drdy_a),
    .dbsy     (dbsy_a),
    .held     (held_a),
    .ready    (req_ready)
  );

  dphase_lane #(.DATA_W(DATA_W), .BEATS(BEATS)) u_lane (
    .line_data (cur_data),
    .be        (cur_be),
    .is_line   (cur_line),
    .beat      (beat),
    .drdy      (drdy_a),
    .d_out     (d_out)
  );

  assign drdy_n   = !drdy_a;
  assign dbsy_n   = !dbsy_a;
  assign bus_held = held_a;

endmodule

// File: rtl/dphase_chk.sv
module dphase_chk #(
  parameter int DATA_W = 64,
  parameter int BEATS  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              drdy_a,
  input logic              dbsy_a,
  input logic              held_a,
  input logic              req_ready,
  input logic              cur_write,
  input logic              cur_line,
  input logic              ioq_head,
  input logic              trdy_n,
  input logic              bus_busy_n,
  input logic [DATA_W-1:0] d_out
);

  int unsigned run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_cnt <= 0;
    else if (drdy_a) run_cnt <= run_cnt + 1;
    else             run_cnt <= 0;
  end

  a_r1_ready_when_free: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !held_a);

  a_r2_start_at_head_on_free_bus: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drdy_a) |-> ($past(ioq_head) && $past(bus_busy_n)));

  a_r3_write_needs_trdy: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(drdy_a) && cur_write) |-> !$past(trdy_n));

  a_r4_beat_run_limit: assert property (@(posedge clk) disable iff (!rst_n)
    drdy_a |-> (run_cnt < BEATS));

  a_r5_busy_only_with_ready: assert property (@(posedge clk) disable iff (!rst_n)
    dbsy_a |-> drdy_a);

  a_r6_partial_never_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (drdy_a && !cur_line) |-> !dbsy_a);

  a_r7_release_clock_held: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dbsy_a) |-> (held_a && !drdy_a));

  a_r7_ready_on_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(held_a) |-> req_ready);

  a_r8_quiet_data_lines: assert property (@(posedge clk) disable iff (!rst_n)
    !drdy_a |-> (d_out == '0));

endmodule

bind dphase_drv dphase_chk #(.DATA_W(DATA_W), .BEATS(BEATS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .drdy_a     (drdy_a),
  .dbsy_a     (dbsy_a),
  .held_a     (held_a),
  .req_ready  (req_ready),
  .cur_write  (cur_write),
  .cur_line   (cur_line),
  .ioq_head   (ioq_head),
  .trdy_n     (trdy_n),
  .bus_busy_n (bus_busy_n),
  .d_out      (d_out)
);

// File: tb/dphase_drv_test.sv
`timescale 1ns/1ps
module dphase_drv_test;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         req_valid, req_write, req_line;
  logic         req_ready;
  logic [7:0]   req_be;
  logic [255:0] req_data;
  logic         ioq_head, trdy_n, bus_busy_n;
  logic         drdy_n, dbsy_n, bus_held;
  logic [63:0]  d_out;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  dphase_drv uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_line(req_line), .req_be(req_be), .req_data(req_data),
    .ioq_head(ioq_head), .trdy_n(trdy_n), .bus_busy_n(bus_busy_n),
    .drdy_n(drdy_n), .dbsy_n(dbsy_n), .d_out(d_out), .bus_held(bus_held)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Expected beat: a line takes chunk i, a partial keeps only enabled lanes.
  function automatic logic [63:0] exp_beat(input bit ln, input logic [7:0] be,
                                           input logic [255:0] dat, input int i);
    logic [63:0] r;
    logic [255:0] sh;
    if (ln) begin
      sh = dat >> (64 * i);
      return sh[63:0];
    end
    r = 64'h0;
    for (int j = 0; j < 8; j++)
      if (be[j]) r = r | (dat[63:0] & (64'hFF << (8 * j)));
    return r;
  endfunction

  function automatic logic [255:0] rnd_line();
    logic [255:0] v;
    for (int k = 0; k < 8; k++) v[32*k +: 32] = $urandom;
    return v;
  endfunction

  task automatic run_txn(input bit wr, input bit ln, input logic [7:0] be,
                         input logic [255:0] dat, input int stall);
    int nb;
    logic [63:0] e;
    @(negedge clk);
    chk(req_ready === 1'b1, "R1 ready before request", {63'h0, req_ready}, 64'h1);
    req_valid = 1'b1; req_write = wr; req_line = ln; req_be = be; req_data = dat;
    ioq_head = 1'b0; trdy_n = 1'b1; bus_busy_n = 1'b1;
    @(negedge clk);
    chk(req_ready === 1'b0, "R1 ready drops after accept", {63'h0, req_ready}, 64'h0);
    req_valid = 1'b0; req_write = ~wr; req_line = ~ln; req_be = ~be; req_data = ~dat;
    for (int s = 0; s < stall; s++) begin
      case ($urandom_range(0, wr ? 2 : 1))
        0: begin ioq_head = 1'b0; bus_busy_n = 1'(($urandom)); trdy_n = 1'(($urandom)); end
        1: begin ioq_head = 1'b1; bus_busy_n = 1'b0; trdy_n = 1'(($urandom)); end
        default: begin ioq_head = 1'b1; bus_busy_n = 1'b1; trdy_n = 1'b1; end
      endcase
      @(negedge clk);
      chk(drdy_n === 1'b1, wr ? "R3 write held back by gate" : "R2 read held back by gate",
          {63'h0, drdy_n}, 64'h1);
    end
    ioq_head = 1'b1; bus_busy_n = 1'b1; trdy_n = wr ? 1'b0 : 1'(($urandom));
    nb = ln ? 4 : 1;
    for (int i = 0; i < nb; i++) begin
      @(negedge clk);
      e = exp_beat(ln, be, dat, i);
      chk(drdy_n === 1'b0, ln ? "R4 drdy on line beat" : "R6 drdy on partial beat",
          {63'h0, drdy_n}, 64'h0);
      chk(dbsy_n === (ln ? 1'b0 : 1'b1), ln ? "R5 dbsy on line beat" : "R6 no dbsy on partial",
          {63'h0, dbsy_n}, {63'h0, !ln});
      chk(d_out === e, ln ? "R4 line chunk order (R9 capture)" : "R6 partial lanes (R9 capture)",
          d_out, e);
      chk(bus_held === 1'b1, "R7 held on beat", {63'h0, bus_held}, 64'h1);
      ioq_head = 1'($urandom); trdy_n = 1'($urandom);
      req_valid = 1'b1; req_data = rnd_line(); req_be = 8'($urandom); req_line = 1'($urandom);
    end
    @(negedge clk);
    req_valid = 1'b0; ioq_head = 1'b0; trdy_n = 1'b1;
    chk(drdy_n === 1'b1, "R4 beat count ends", {63'h0, drdy_n}, 64'h1);
    chk(dbsy_n === 1'b1, "R5 dbsy released", {63'h0, dbsy_n}, 64'h1);
    chk(d_out === 64'h0, "R8 data quiet", d_out, 64'h0);
    if (ln) begin
      chk(bus_held === 1'b1, "R7 release clock held", {63'h0, bus_held}, 64'h1);
      chk(req_ready === 1'b0, "R7 not ready in release clock", {63'h0, req_ready}, 64'h0);
      @(negedge clk);
    end
    chk(bus_held === 1'b0, "R7 bus freed", {63'h0, bus_held}, 64'h0);
    chk(req_ready === 1'b1, "R7 ready with free bus", {63'h0, req_ready}, 64'h1);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_line = 1'b0;
    req_be = 8'h00; req_data = '0; ioq_head = 1'b0; trdy_n = 1'b1; bus_busy_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(drdy_n === 1'b1, "R1 reset drdy", {63'h0, drdy_n}, 64'h1);
    chk(dbsy_n === 1'b1, "R1 reset dbsy", {63'h0, dbsy_n}, 64'h1);
    chk(bus_held === 1'b0, "R1 reset held", {63'h0, bus_held}, 64'h0);
    chk(req_ready === 1'b1, "R1 reset ready", {63'h0, req_ready}, 64'h1);
    chk(d_out === 64'h0, "R8 reset data", d_out, 64'h0);
    rst_n = 1'b1;

    // Directed corners.
    run_txn(1'b0, 1'b1, 8'h00, rnd_line(), 0);   // R2 read line, immediate start
    run_txn(1'b1, 1'b1, 8'h00, rnd_line(), 6);   // R3 write line, long stall
    run_txn(1'b0, 1'b0, 8'h00, rnd_line(), 1);   // R6 partial, no lanes enabled
    run_txn(1'b1, 1'b0, 8'hFF, rnd_line(), 3);   // R6 partial, all lanes
    run_txn(1'b1, 1'b0, 8'h81, rnd_line(), 2);   // R6 partial, edge lanes only
    run_txn(1'b0, 1'b0, 8'h5A, rnd_line(), 0);   // R6 back-to-back partial

    // Constrained random mix.
    for (int n = 0; n < 60; n++)
      run_txn(1'($urandom), 1'($urandom), 8'($urandom), rnd_line(), $urandom_range(0, 5));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule